// File: doc/BRIEF.md
# Auto-Incrementing Colour Palette Loader

This block holds a 256-entry colour lookup table of 24-bit entries (8 bits each for red, green and blue). A bus master fills it through a window of four 32-bit registers. It first writes a start index into the pointer register. It then streams colour bytes into the data register. The block splits every data word into byte-wide colour components and sends them to a staging stage in the fixed order red, green, blue. When blue arrives, the entry is complete: the block writes it to the table and moves the pointer to the next index. A packed word can therefore close one entry and open the next, and the master never has to reload the index between words.

An input pin selects one of two modes. In packed mode each word supplies four components. In top-byte mode each word supplies one component, taken from its most significant byte. Two more registers in the window are plain 32-bit storage. A separate synchronous pixel port returns the stored entry for an 8-bit index.

Top module: `clut_seq_loader`

## Requirements
- R1: Register select encoding on `wr_sel`/`rd_sel`: 0 is the entry pointer, 1 is colour data, 2 and 3 are general storage registers; a read of select 1 returns zero.
- R2: A write to select 0 loads the entry pointer from `wr_data[7:0]`, returns the component position to red and discards any partly staged entry; a read of select 0 returns the pointer in bits 7:0 with the upper bits zero.
- R3: In packed mode (`top_byte_mode`=0) a data write supplies four components taken in the order bits 31:24, 23:16, 15:8, 7:0, each assigned to red, green, blue of consecutive entries in turn.
- R4: In top-byte mode (`top_byte_mode`=1) a data write supplies one component from bits 31:24 only; bits 23:0 have no effect.
- R5: A table entry changes only when its blue component arrives; red and green alone leave the stored entry unchanged.
- R6: The entry pointer advances by one after each completed entry and wraps from 255 to 0; without a pointer or data write it holds.
- R7: Registers 2 and 3 store all 32 written bits and read them back unchanged.
- R8: `pix_color` shows the table entry for the `pix_index` sampled at the previous rising clock edge, in the format {red, green, blue}.
- R9: After reset the pointer, component position, storage registers, table contents and `pix_color` are all zero.
- R10: Register reads are combinational from `rd_sel`; a completed write is visible on the cycle after its clock edge.
- R11: A packed word that starts at a blue position completes two entries in the same write, and the pointer advances by two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data |
| top_byte_mode | input | 1 | 1: one component per word from bits 31:24; 0: four packed components |
| pix_index | input | 8 | Table index for pixel lookup |
| pix_color | output | 24 | Entry {red, green, blue} for the index sampled on the previous edge |

## Verification
Register writes and table updates take effect at the clock edge that captures the strobe. The bench drives on the falling edge and reads the pointer and storage registers on the next falling edge, half a cycle after the capturing edge. Pixel lookups are due one edge after the index is presented. The bench changes the index on a falling edge, confirms that `pix_color` still shows the previous entry, and then checks the new entry on the following falling edge. Table contents are checked by sweeping all 256 indices against byte streams computed arithmetically.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        C_RED = 2'd0,
        C_GRN = 2'd1,
        C_BLU = 2'd2
    } comp_e;

    localparam logic [1:0] SEL_PTR  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_REGA = 2'd2;
    localparam logic [1:0] SEL_REGB = 2'd3;

endpackage

// File: rtl/clut_regfile.sv
module clut_regfile
    import clut_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    input  logic [IDX_W-1:0] ptr,
    output logic [BUS_W-1:0] rd_data,
    output logic             ptr_load,
    output logic             data_wr
);

    typedef struct packed {
        logic [BUS_W-1:0] rega;
        logic [BUS_W-1:0] regb;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ptr_load = 1'b0;
        data_wr  = 1'b0;
        if (wr_valid) begin
            unique case (wr_sel)
                SEL_PTR:  ptr_load  = 1'b1;
                SEL_DATA: data_wr   = 1'b1;
                SEL_REGA: st_d.rega = wr_data;
                default:  st_d.regb = wr_data;
            endcase
        end
        unique case (rd_sel)
            SEL_PTR:  rd_data = {{(BUS_W-IDX_W){1'b0}}, ptr};
            SEL_DATA: rd_data = '0;
            SEL_REGA: rd_data = st_q.rega;
            default:  rd_data = st_q.regb;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/clut_sequencer.sv
module clut_sequencer
    import clut_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    parameter int NPORT  = 2,
    localparam int SLOTS = BUS_W / COMP_W,
    localparam int ENT_W = 3 * COMP_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ptr_load,
    input  logic                         data_wr,
    input  logic                         top_byte_mode,
    input  logic [BUS_W-1:0]             wr_data,
    output logic [IDX_W-1:0]             ptr,
    output comp_e                        comp,
    output logic [NPORT-1:0]             wen,
    output logic [NPORT-1:0][IDX_W-1:0]  waddr,
    output logic [NPORT-1:0][ENT_W-1:0]  wdata
);

    typedef struct packed {
        logic [IDX_W-1:0]  addr;
        comp_e             comp;
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
    } seq_t;

    seq_t              st_d, st_q;
    logic [COMP_W-1:0] byte_v;

    always_comb begin
        st_d   = st_q;
        wen    = '0;
        waddr  = '0;
        wdata  = '0;
        byte_v = '0;
        if (ptr_load) begin
            st_d.addr = wr_data[IDX_W-1:0];
            st_d.comp = C_RED;
            st_d.red  = '0;
            st_d.grn  = '0;
        end else if (data_wr) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (s == 0 || !top_byte_mode) begin
                    byte_v = wr_data[BUS_W-1-s*COMP_W -: COMP_W];
                    unique case (st_d.comp)
                        C_RED: begin
                            st_d.red  = byte_v;
                            st_d.comp = C_GRN;
                        end
                        C_GRN: begin
                            st_d.grn  = byte_v;
                            st_d.comp = C_BLU;
                        end
                        default: begin
                            if (!wen[0]) begin
                                wen[0]   = 1'b1;
                                waddr[0] = st_d.addr;
                                wdata[0] = {st_d.red, st_d.grn, byte_v};
                            end else begin
                                wen[NPORT-1]   = 1'b1;
                                waddr[NPORT-1] = st_d.addr;
                                wdata[NPORT-1] = {st_d.red, st_d.grn, byte_v};
                            end
                            st_d.addr = st_d.addr + 1'b1;
                            st_d.comp = C_RED;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{addr: '0, comp: C_RED, red: '0, grn: '0};
        else        st_q <= st_d;
    end

    assign ptr  = st_q.addr;
    assign comp = st_q.comp;

endmodule

// File: rtl/clut_palette.sv
module clut_palette #(
    parameter int IDX_W = 8,
    parameter int ENT_W = 24,
    parameter int NPORT = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             wen,
    input  logic [NPORT-1:0][IDX_W-1:0]  waddr,
    input  logic [NPORT-1:0][ENT_W-1:0]  wdata,
    input  logic [IDX_W-1:0]             pix_index,
    output logic [ENT_W-1:0]             pix_color
);

    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic [ENT_W-1:0] pix_d, pix_q;

    always_comb begin
        mem_d = mem_q;
        for (int p = 0; p < NPORT; p++) begin
            if (wen[p]) mem_d[waddr[p]] = wdata[p];
        end
        pix_d = mem_q[pix_index];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
            pix_q <= '0;
        end else begin
            mem_q <= mem_d;
            pix_q <= pix_d;
        end
    end

    assign pix_color = pix_q;

endmodule

// File: rtl/clut_seq_loader.sv
module clut_seq_loader
    import clut_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    localparam int SLOTS = BUS_W / COMP_W,
    localparam int ENT_W = 3 * COMP_W,
    localparam int NPORT = 1 + (SLOTS - 1) / 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [BUS_W-1:0] rd_data,
    input  logic             top_byte_mode,
    input  logic [IDX_W-1:0] pix_index,
    output logic [ENT_W-1:0] pix_color
);

    logic                        ptr_load;
    logic                        data_wr;
    logic [IDX_W-1:0]            ptr;
    comp_e                       comp;
    logic [NPORT-1:0]            wen;
    logic [NPORT-1:0][IDX_W-1:0] waddr;
    logic [NPORT-1:0][ENT_W-1:0] wdata;

    clut_regfile #(.BUS_W(BUS_W), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .ptr      (ptr),
        .rd_data  (rd_data),
        .ptr_load (ptr_load),
        .data_wr  (data_wr)
    );

    clut_sequencer #(.BUS_W(BUS_W), .COMP_W(COMP_W), .IDX_W(IDX_W), .NPORT(NPORT)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ptr_load      (ptr_load),
        .data_wr       (data_wr),
        .top_byte_mode (top_byte_mode),
        .wr_data       (wr_data),
        .ptr           (ptr),
        .comp          (comp),
        .wen           (wen),
        .waddr         (waddr),
        .wdata         (wdata)
    );

    clut_palette #(.IDX_W(IDX_W), .ENT_W(ENT_W), .NPORT(NPORT)) u_pal (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (wen),
        .waddr     (waddr),
        .wdata     (wdata),
        .pix_index (pix_index),
        .pix_color (pix_color)
    );

endmodule

// File: rtl/clut_seq_loader_chk.sv
module clut_seq_loader_chk
    import clut_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int IDX_W = 8,
    parameter int ENT_W = 24,
    parameter int NPORT = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_valid,
    input logic [1:0]                  wr_sel,
    input logic [BUS_W-1:0]            wr_data,
    input logic                        top_byte_mode,
    input logic [IDX_W-1:0]            ptr,
    input logic [1:0]                  comp,
    input logic [NPORT-1:0]            wen,
    input logic [NPORT-1:0][IDX_W-1:0] waddr
);

    assert_comp_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        comp != 2'd3);

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == SEL_PTR) |=>
            (ptr == $past(wr_data[IDX_W-1:0]) && comp == C_RED));

    assert_table_write_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|wen) |-> (wr_valid && wr_sel == SEL_DATA));

    assert_top_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        top_byte_mode |-> !wen[NPORT-1] || NPORT == 1);

    assert_two_entries_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (NPORT > 1 && wen[NPORT-1]) |->
            (wen[0] && waddr[NPORT-1] == waddr[0] + 1'b1));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && (wr_sel == SEL_PTR || wr_sel == SEL_DATA)) |=>
            ($stable(ptr) && $stable(comp)));

    assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wen[0] && !(NPORT > 1 && wen[NPORT-1])) |=>
            (ptr == $past(waddr[0]) + 1'b1));

endmodule

bind clut_seq_loader clut_seq_loader_chk #(
    .BUS_W(BUS_W), .IDX_W(IDX_W), .ENT_W(ENT_W), .NPORT(NPORT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .top_byte_mode (top_byte_mode),
    .ptr           (ptr),
    .comp          (comp),
    .wen           (wen),
    .waddr         (waddr)
);

// File: tb/clut_seq_loader_test.sv
module clut_seq_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        top_byte_mode = 1'b0;
    logic [7:0]  pix_index = '0;
    logic [23:0] pix_color;

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_mem [256];

    always #2 clk = ~clk;

    clut_seq_loader uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .rd_sel        (rd_sel),
        .rd_data       (rd_data),
        .top_byte_mode (top_byte_mode),
        .pix_index     (pix_index),
        .pix_color     (pix_color)
    );

    function automatic logic [7:0] fa(int n); return 8'((n * 37 + 11) & 255); endfunction
    function automatic logic [7:0] fb(int n); return 8'((n * 53 + 200) & 255); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // drive on falling edge, strobe captured at next rising edge, back at falling edge
    task automatic reg_wr(logic [1:0] sel, logic [31:0] d);
        wr_valid = 1'b1;
        wr_sel   = sel;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_data  = 32'h0;
    endtask

    task automatic rd_chk(string req, logic [1:0] sel, logic [31:0] expv);
        rd_sel = sel;
        #0.5;
        chk(req, rd_data, expv);
    endtask

    task automatic pix_chk(string req, int idx);
        pix_index = 8'(idx);
        @(negedge clk);
        chk(req, {8'h0, pix_color}, {8'h0, exp_mem[idx]});
    endtask

    initial begin
        #300000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd_chk("R9 ptr", 2'd0, 32'h0);
        rd_chk("R9 rega", 2'd2, 32'h0);
        rd_chk("R9 regb", 2'd3, 32'h0);
        chk("R9 pix", {8'h0, pix_color}, 32'h0);
        pix_chk("R9 entry 200", 200);

        // R3 R6 R11 packed sweep of whole table from index 0
        top_byte_mode = 1'b0;
        reg_wr(2'd0, 32'h0);
        rd_chk("R2 ptr 0", 2'd0, 32'h0);
        for (int w = 0; w < 192; w++) begin
            reg_wr(2'd1, {fa(4*w), fa(4*w+1), fa(4*w+2), fa(4*w+3)});
            rd_chk("R6 R11 ptr after packed word", 2'd0, 32'((4*(w+1)/3) % 256));
            if (w == 0) begin
                exp_mem[0] = {fa(0), fa(1), fa(2)};
                pix_chk("R5 entry 1 untouched with only red staged", 1);
                pix_chk("R3 entry 0", 0);
            end
        end
        for (int e = 0; e < 256; e++) exp_mem[e] = {fa(3*e), fa(3*e+1), fa(3*e+2)};
        for (int e = 0; e < 256; e++) pix_chk("R3 R8 packed entry", e);

        // R8 one-cycle latency: new index not visible before the edge
        pix_index = 8'd7;
        @(negedge clk);
        pix_index = 8'd9;
        #0.5;
        chk("R8 previous entry held before edge", {8'h0, pix_color}, {8'h0, exp_mem[7]});
        @(negedge clk);
        chk("R8 new entry after edge", {8'h0, pix_color}, {8'h0, exp_mem[9]});

        // R4 R6 top-byte mode, wrap across 255 -> 0, low bytes junk
        top_byte_mode = 1'b1;
        reg_wr(2'd0, 32'hFFFF_FFFA);
        rd_chk("R2 ptr load low bits only", 2'd0, 32'd250);
        for (int k = 0; k < 30; k++) begin
            reg_wr(2'd1, {fb(k), 24'hA5C3_5A});
        end
        rd_chk("R6 ptr wrapped", 2'd0, 32'd4);
        for (int j = 0; j < 10; j++) exp_mem[(250 + j) % 256] = {fb(3*j), fb(3*j+1), fb(3*j+2)};
        for (int e = 240; e < 256; e++) pix_chk("R4 top-byte entry", e);
        for (int e = 0; e < 8; e++) pix_chk("R4 top-byte entry", e);

        // R5 partial entry invisible, R2 reload discards staging
        reg_wr(2'd0, 32'd100);
        reg_wr(2'd1, 32'h1100_0000);
        reg_wr(2'd1, 32'h2200_0000);
        pix_chk("R5 entry 100 unchanged after red and green", 100);
        rd_chk("R5 ptr stays", 2'd0, 32'd100);
        reg_wr(2'd0, 32'd100);
        reg_wr(2'd1, 32'h3300_0000);
        pix_chk("R2 staged data discarded", 100);
        reg_wr(2'd1, 32'h4400_0000);
        reg_wr(2'd1, 32'h5500_0000);
        exp_mem[100] = 24'h334455;
        pix_chk("R2 R5 entry after reload", 100);
        rd_chk("R6 ptr 101", 2'd0, 32'd101);

        // R11 packed word starting at blue, pointer moved past entry 100 region
        top_byte_mode = 1'b0;
        reg_wr(2'd0, 32'd60);
        reg_wr(2'd1, 32'h0102_0304);
        reg_wr(2'd1, 32'h0506_0708);
        rd_chk("R11 ptr before blue-start word", 2'd0, 32'd62);
        reg_wr(2'd1, 32'h090A_0B0C);
        rd_chk("R11 ptr advances by two", 2'd0, 32'd64);
        exp_mem[60] = 24'h010203;
        exp_mem[61] = 24'h040506;
        exp_mem[62] = 24'h07_0809;
        exp_mem[63] = 24'h0A0B0C;
        for (int e = 59; e < 65; e++) pix_chk("R11 entries", e);

        // R1 R7 R10 storage registers and data read
        reg_wr(2'd2, 32'hDEAD_BEEF);
        reg_wr(2'd3, 32'h1234_5678);
        rd_chk("R7 rega", 2'd2, 32'hDEAD_BEEF);
        rd_chk("R7 regb", 2'd3, 32'h1234_5678);
        rd_chk("R1 data reads zero", 2'd1, 32'h0);
        rd_chk("R1 R10 ptr unaffected by storage writes", 2'd0, 32'd64);
        pix_chk("R1 table unaffected by storage writes", 64);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule